// File: doc/BRIEF.md
# Aliased Floating-Point Register File

This block holds the floating-point operand state of a processor core in a single storage array. Each access views that array at one of three widths: 32-bit single words, 64-bit doubles and 128-bit quads. The views overlap, so a single word is always one half of some double, and a double is always one half of some quad. Every port carries a 2-bit size code and a 5-bit register specifier. A narrow write changes only the words it names, so the rest of the storage stays as it was.

The array holds a lower bank and an upper bank. The lower bank is 16 doubles, which can also be seen as 32 singles or 8 quads. The upper bank adds 16 more doubles, which also form 8 more quads. The upper bank can be reached only by double and quad accesses, and only while the extension input is high. A specifier that is not legal for its size raises a per-port flag. Such a write leaves the storage unchanged. Such a read returns zero.

There is one write port and two read ports. Reads are registered. A read issued in the same cycle as a write to the same storage returns the contents from before that write.

Top module: `fpr_alias_file`

## Requirements
- R1: While the synchronous active-high reset is high, both read data outputs and all three illegal flags are zero from the first clock edge onwards.
- R2: Size code 2'b01 is single. Specifier n (0..31) names one 32-bit word, returned in bits [31:0]. Word n is the high half (bits [63:32]) of the double with register number n with bit 0 cleared when n is even, and the low half when n is odd. A double read of an even lower number r returns {word r, word r+1} in bits [63:0]. All unused upper bits are zero.
- R3: A single write changes only its own 32-bit half of a double; the other half keeps its value.
- R4: Size code 2'b10 is double and 2'b11 is quad. Their register number is {spec[0], spec[4:1], 1'b0}, so spec[0]=1 selects the upper bank (numbers 32..62). A quad with number q returns double q in bits [127:64] and double q+2 in bits [63:0].
- R5: A legal quad write updates all 128 bits in one cycle. The doubles q and q+2, and the singles q..q+3 (lower bank), read back the written parts.
- R6: A quad specifier with spec[1]=1 is illegal. A write with it leaves the storage unchanged and raises wr_bad one cycle later. A read with it raises the port's bad flag and returns zero.
- R7: A double or quad access with spec[0]=1 while ext_en is low is illegal, and it is handled as in R6. Single accesses are legal for every specifier, whatever the value of ext_en.
- R8: Size code 2'b00 is reserved. Any access with it is illegal and is handled as in R6.
- R9: The upper bank is separate storage. Writes to upper doubles do not change any lower single, double or quad, and no single specifier reaches the upper bank.
- R10: Read data and read flags appear one cycle after the request. A read in the same cycle as an overlapping write returns the old contents; a read one cycle later returns the new ones.
- R11: The two read ports work independently and can read different sizes and registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en | input | 1 | Enables access to the upper bank |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | Write size code |
| wr_spec | input | 5 | Write register specifier |
| wr_data | input | 128 | Write data, right-aligned for single and double |
| wr_bad | output | 1 | Previous write was illegal and was dropped |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_spec | input | 5 | Read port 0 specifier |
| rd0_data | output | 128 | Read port 0 data, right-aligned, zero-filled |
| rd0_bad | output | 1 | Read port 0 request was illegal |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_spec | input | 5 | Read port 1 specifier |
| rd1_data | output | 128 | Read port 1 data, right-aligned, zero-filled |
| rd1_bad | output | 1 | Read port 1 request was illegal |

## Verification
Each result of this block is due exactly one cycle after the edge that captures its request. This holds for read data, the read flags and wr_bad. Written data becomes visible to a read captured at the next edge. The bench changes inputs on the falling edge, so the request is captured by the following rising edge. It then compares at the next falling edge, which is the middle of the cycle in which the registered result is valid. For the same-cycle overlap case, the bench computes the expected value from its shadow model before it applies the write to that model. In the following cycle it compares against the updated model.

// File: rtl/fpra_pkg.sv
package fpra_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_PAIR = 2'b10,
    SZ_QUAD = 2'b11
  } fsize_e;

  // Words per quad row; fixed by the three aliased widths.
  localparam int unsigned LANES = 4;
endpackage

// File: rtl/fpra_decode.sv
module fpra_decode
  import fpra_pkg::*;
#(
  parameter int unsigned SPEC_W = 5,
  localparam int unsigned ROW_W = SPEC_W - 1
) (
  input  logic [1:0]        size,
  input  logic [SPEC_W-1:0] spec,
  input  logic              ext_en,
  output logic [ROW_W-1:0]  row,
  output logic [LANES-1:0]  lane_mask,
  output logic [1:0]        first_lane,
  output logic              bad
);
  // Lane 0 is the most significant word of a quad row.
  always_comb begin
    row        = '0;
    lane_mask  = '0;
    first_lane = '0;
    bad        = 1'b0;
    case (fsize_e'(size))
      SZ_WORD: begin
        row        = {1'b0, spec[SPEC_W-1:2]};
        first_lane = spec[1:0];
        lane_mask  = LANES'(1) << spec[1:0];
      end
      SZ_PAIR: begin
        row        = {spec[0], spec[SPEC_W-1:2]};
        first_lane = {spec[1], 1'b0};
        lane_mask  = spec[1] ? LANES'(4'b1100) : LANES'(4'b0011);
        bad        = spec[0] & ~ext_en;
      end
      SZ_QUAD: begin
        row        = {spec[0], spec[SPEC_W-1:2]};
        first_lane = 2'b00;
        lane_mask  = '1;
        bad        = spec[1] | (spec[0] & ~ext_en);
      end
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/fpra_lane_mem.sv
module fpra_lane_mem #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned NRD    = 2,
  localparam int unsigned DEPTH = 2 ** ROW_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [ROW_W-1:0]             waddr,
  input  logic [WORD_W-1:0]            wdata,
  input  logic [NRD-1:0][ROW_W-1:0]    raddr,
  output logic [NRD-1:0][WORD_W-1:0]   rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first registered outputs: a same-edge write is not seen.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) rdata[p] <= '0;
      else     rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/fpra_rd_port.sv
module fpra_rd_port
  import fpra_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned DATA_W = LANES * WORD_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   size,
  input  logic [1:0]                   first_lane,
  input  logic                         bad,
  input  logic [LANES-1:0][WORD_W-1:0] words,
  output logic [DATA_W-1:0]            data,
  output logic                         bad_q
);
  fsize_e     size_q;
  logic [1:0] lane_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q <= SZ_NONE;
      lane_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      size_q <= fsize_e'(size);
      lane_q <= first_lane;
      bad_q  <= bad;
    end
  end

  always_comb begin
    data = '0;
    if (!bad_q) begin
      case (size_q)
        SZ_WORD: data[WORD_W-1:0] = words[lane_q];
        SZ_PAIR: data[2*WORD_W-1:0] = {words[lane_q], words[{lane_q[1], 1'b1}]};
        SZ_QUAD: begin
          for (int i = 0; i < LANES; i++)
            data[(LANES-1-i)*WORD_W +: WORD_W] = words[i];
        end
        default: data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpr_alias_file.sv
module fpr_alias_file
  import fpra_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned SPEC_W = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ext_en,
  input  logic                    wr_en,
  input  logic [1:0]              wr_size,
  input  logic [SPEC_W-1:0]       wr_spec,
  input  logic [4*WORD_W-1:0]     wr_data,
  output logic                    wr_bad,
  input  logic [1:0]              rd0_size,
  input  logic [SPEC_W-1:0]       rd0_spec,
  output logic [4*WORD_W-1:0]     rd0_data,
  output logic                    rd0_bad,
  input  logic [1:0]              rd1_size,
  input  logic [SPEC_W-1:0]       rd1_spec,
  output logic [4*WORD_W-1:0]     rd1_data,
  output logic                    rd1_bad
);
  localparam int unsigned ROW_W  = SPEC_W - 1;
  localparam int unsigned NRD    = 2;
  localparam int unsigned DATA_W = LANES * WORD_W;

  // ---------------- write side ----------------
  logic [ROW_W-1:0]  w_row;
  logic [LANES-1:0]  w_mask;
  logic [1:0]        w_first;
  logic              w_bad;
  logic [LANES-1:0]  lane_we;
  logic [LANES-1:0][WORD_W-1:0] lane_wd;

  fpra_decode #(.SPEC_W(SPEC_W)) u_wdec (
    .size(wr_size), .spec(wr_spec), .ext_en(ext_en),
    .row(w_row), .lane_mask(w_mask), .first_lane(w_first), .bad(w_bad)
  );

  assign lane_we = {LANES{wr_en & ~w_bad}} & w_mask;

  // Steer the right-aligned write data onto the storage lanes.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      case (fsize_e'(wr_size))
        SZ_QUAD: lane_wd[i] = wr_data[(LANES-1-i)*WORD_W +: WORD_W];
        SZ_PAIR: lane_wd[i] = (i % 2 == 0) ? wr_data[2*WORD_W-1:WORD_W] : wr_data[WORD_W-1:0];
        default: lane_wd[i] = wr_data[WORD_W-1:0];
      endcase
    end
  end

  logic unused_first;
  assign unused_first = ^w_first;

  always_ff @(posedge clk) begin
    if (rst) wr_bad <= 1'b0;
    else     wr_bad <= wr_en & w_bad;
  end

  // ---------------- read side ----------------
  logic [NRD-1:0][1:0]        r_size;
  logic [NRD-1:0][SPEC_W-1:0] r_spec;
  logic [NRD-1:0][ROW_W-1:0]  r_row;
  logic [NRD-1:0][1:0]        r_first;
  logic [NRD-1:0]             r_bad;
  logic [NRD-1:0][LANES-1:0]  r_mask;
  logic [NRD-1:0][DATA_W-1:0] r_data;
  logic [NRD-1:0]             r_flag;
  logic [LANES-1:0][NRD-1:0][WORD_W-1:0] lane_rd;
  logic [NRD-1:0][LANES-1:0][WORD_W-1:0] port_words;

  assign r_size[0] = rd0_size;
  assign r_size[1] = rd1_size;
  assign r_spec[0] = rd0_spec;
  assign r_spec[1] = rd1_spec;

  logic unused_mask;
  assign unused_mask = ^r_mask;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    fpra_decode #(.SPEC_W(SPEC_W)) u_rdec (
      .size(r_size[p]), .spec(r_spec[p]), .ext_en(ext_en),
      .row(r_row[p]), .lane_mask(r_mask[p]), .first_lane(r_first[p]), .bad(r_bad[p])
    );

    for (genvar i = 0; i < LANES; i++) begin : g_pw
      assign port_words[p][i] = lane_rd[i][p];
    end

    fpra_rd_port #(.WORD_W(WORD_W)) u_fmt (
      .clk(clk), .rst(rst), .size(r_size[p]), .first_lane(r_first[p]),
      .bad(r_bad[p]), .words(port_words[p]), .data(r_data[p]), .bad_q(r_flag[p])
    );
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fpra_lane_mem #(.WORD_W(WORD_W), .ROW_W(ROW_W), .NRD(NRD)) u_mem (
      .clk(clk), .rst(rst), .we(lane_we[i]), .waddr(w_row), .wdata(lane_wd[i]),
      .raddr(r_row), .rdata(lane_rd[i])
    );
  end

  assign rd0_data = r_data[0];
  assign rd1_data = r_data[1];
  assign rd0_bad  = r_flag[0];
  assign rd1_bad  = r_flag[1];

  // ---------------- assertions ----------------
  assert_word_one_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b01) |-> ($countones(lane_we) == 1));

  assert_quad_all_lanes_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b11 && !wr_spec[1] && (!wr_spec[0] || ext_en)) |-> (lane_we == '1));

  assert_misalign_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b11 && wr_spec[1]) |=> wr_bad);

  assert_bad_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    w_bad |-> (lane_we == '0));

  assert_upper_locked_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ext_en && wr_size[1] && wr_spec[0]) |=> wr_bad);

  assert_word_always_ok_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b01) |=> !wr_bad);

  assert_reserved_size_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_size == 2'b00) |=> wr_bad);

  assert_no_flag_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_bad);
endmodule

// File: tb/sim_fpr_alias_file.sv
`timescale 1ns/1ps
module sim_fpr_alias_file;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ext_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_size = 2'b00;
  logic [4:0]   wr_spec = '0;
  logic [127:0] wr_data = '0;
  logic         wr_bad;
  logic [1:0]   rd0_size = 2'b11, rd1_size = 2'b11;
  logic [4:0]   rd0_spec = '0, rd1_spec = '0;
  logic [127:0] rd0_data, rd1_data;
  logic         rd0_bad, rd1_bad;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] sh [64];

  always #4 clk = ~clk;

  fpr_alias_file u0 (
    .clk(clk), .rst(rst), .ext_en(ext_en), .wr_en(wr_en), .wr_size(wr_size),
    .wr_spec(wr_spec), .wr_data(wr_data), .wr_bad(wr_bad),
    .rd0_size(rd0_size), .rd0_spec(rd0_spec), .rd0_data(rd0_data), .rd0_bad(rd0_bad),
    .rd1_size(rd1_size), .rd1_spec(rd1_spec), .rd1_data(rd1_data), .rd1_bad(rd1_bad)
  );

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(logic [1:0] sz, logic [4:0] sp);
    case (sz)
      2'b01:   return 1'b1;
      2'b10:   return !(sp[0] && !ext_en);
      2'b11:   return !sp[1] && !(sp[0] && !ext_en);
      default: return 1'b0;
    endcase
  endfunction

  function automatic int base(logic [1:0] sz, logic [4:0] sp);
    if (sz == 2'b01) return int'(sp);
    return int'({sp[0], sp[4:1], 1'b0});
  endfunction

  function automatic logic [127:0] model(logic [1:0] sz, logic [4:0] sp);
    int b = base(sz, sp);
    if (!legal(sz, sp)) return '0;
    case (sz)
      2'b01:   return {96'b0, sh[b]};
      2'b10:   return {64'b0, sh[b], sh[b+1]};
      default: return {sh[b], sh[b+1], sh[b+2], sh[b+3]};
    endcase
  endfunction

  task automatic shadow_wr(logic [1:0] sz, logic [4:0] sp, logic [127:0] d);
    int b = base(sz, sp);
    if (!legal(sz, sp)) return;
    case (sz)
      2'b01: sh[b] = d[31:0];
      2'b10: begin sh[b] = d[63:32]; sh[b+1] = d[31:0]; end
      default: for (int i = 0; i < 4; i++) sh[b+i] = d[(3-i)*32 +: 32];
    endcase
  endtask

  task automatic wr(string tag, logic [1:0] sz, logic [4:0] sp, logic [127:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_size = sz; wr_spec = sp; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    chk({tag, " wr_bad"}, {127'b0, wr_bad}, {127'b0, !legal(sz, sp)});
    shadow_wr(sz, sp, d);
  endtask

  task automatic rd(string tag, int port, logic [1:0] sz, logic [4:0] sp);
    @(negedge clk);
    if (port == 0) begin rd0_size = sz; rd0_spec = sp; end
    else           begin rd1_size = sz; rd1_spec = sp; end
    @(negedge clk);
    if (port == 0) begin
      chk({tag, " rd0_data"}, rd0_data, model(sz, sp));
      chk({tag, " rd0_bad"}, {127'b0, rd0_bad}, {127'b0, !legal(sz, sp)});
    end else begin
      chk({tag, " rd1_data"}, rd1_data, model(sz, sp));
      chk({tag, " rd1_bad"}, {127'b0, rd1_bad}, {127'b0, !legal(sz, sp)});
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 rd0_data in reset", rd0_data, '0);
    chk("R1 rd1_data in reset", rd1_data, '0);
    chk("R1 flags in reset", {125'b0, wr_bad, rd0_bad, rd1_bad}, '0);
    rst = 1'b0;
  endtask

  task automatic t_singles();
    for (int n = 0; n < 32; n++)
      wr("R2 fill", 2'b01, 5'(n), {96'b0, 32'(n * 32'h9E37_79B1 + 32'h1357)});
    for (int n = 0; n < 32; n++) rd("R2 single", 0, 2'b01, 5'(n));
    for (int r = 0; r < 32; r += 2) rd("R2 double", 1, 2'b10, 5'(r));
    for (int q = 0; q < 32; q += 4) rd("R4 lower quad", 0, 2'b11, 5'(q));
  endtask

  task automatic t_half();
    wr("R3 base", 2'b10, 5'd6, {64'b0, 32'hAAAA_0001, 32'hBBBB_0002});
    wr("R3 low", 2'b01, 5'd7, {96'b0, 32'hCCCC_0003});
    rd("R3 keep high", 0, 2'b10, 5'd6);
    wr("R3 high", 2'b01, 5'd6, {96'b0, 32'hDDDD_0004});
    rd("R3 keep low", 1, 2'b10, 5'd6);
  endtask

  task automatic t_upper();
    ext_en = 1'b1;
    for (int s = 1; s < 32; s += 2)
      wr("R9 fill upper", 2'b10, 5'(s), {64'b0, 32'(s * 32'h0101_0101), 32'(~(s * 32'h2468_0001))});
    for (int q = 0; q < 32; q += 4) rd("R9 lower intact", 0, 2'b11, 5'(q));
    rd("R9 single lower", 1, 2'b01, 5'd0);
    rd("R9 single top", 1, 2'b01, 5'd31);
    rd("R4 upper double", 0, 2'b10, 5'd1);
    rd("R4 upper double 62", 1, 2'b10, 5'd31);
    rd("R4 upper quad", 0, 2'b11, 5'd1);
    rd("R4 upper quad 60", 1, 2'b11, 5'd29);
  endtask

  task automatic t_quad();
    wr("R5 lower", 2'b11, 5'd8, 128'h1111_2222_3333_4444_5555_6666_7777_8888);
    for (int n = 8; n < 12; n++) rd("R5 single", 0, 2'b01, 5'(n));
    rd("R5 double lo", 1, 2'b10, 5'd8);
    rd("R5 double hi", 1, 2'b10, 5'd10);
    wr("R5 upper", 2'b11, 5'd5, 128'h9999_AAAA_BBBB_CCCC_DDDD_EEEE_FFFF_0123);
    rd("R5 upper double", 0, 2'b10, 5'd5);
    rd("R5 upper double2", 0, 2'b10, 5'd7);
    rd("R9 lower untouched", 1, 2'b11, 5'd4);
  endtask

  task automatic t_illegal();
    wr("R6 misaligned", 2'b11, 5'd2, 128'hDEAD_BEEF_DEAD_BEEF_DEAD_BEEF_DEAD_BEEF);
    rd("R6 read misaligned", 0, 2'b11, 5'd2);
    rd("R6 quad 0 intact", 1, 2'b11, 5'd0);
    ext_en = 1'b0;
    wr("R7 upper locked", 2'b10, 5'd3, {64'b0, 64'hFEED_FACE_CAFE_F00D});
    rd("R7 read locked", 0, 2'b10, 5'd1);
    rd("R7 quad locked", 1, 2'b11, 5'd1);
    wr("R7 single still ok", 2'b01, 5'd31, {96'b0, 32'h0BAD_F00D});
    rd("R7 single readable", 0, 2'b01, 5'd31);
    wr("R8 reserved", 2'b00, 5'd0, '1);
    rd("R8 read reserved", 1, 2'b00, 5'd0);
    ext_en = 1'b1;
    rd("R7 upper intact", 0, 2'b10, 5'd3);
    rd("R8 quad 0 intact", 1, 2'b11, 5'd0);
  endtask

  task automatic t_overlap();
    logic [127:0] old_d, old_q;
    @(negedge clk);
    old_d = model(2'b10, 5'd12);
    old_q = model(2'b11, 5'd12);
    wr_en = 1'b1; wr_size = 2'b10; wr_spec = 5'd12; wr_data = {64'b0, 64'h0123_4567_89AB_CDEF};
    rd0_size = 2'b10; rd0_spec = 5'd12;
    rd1_size = 2'b11; rd1_spec = 5'd12;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 old double", rd0_data, old_d);
    chk("R10 old quad", rd1_data, old_q);
    shadow_wr(2'b10, 5'd12, {64'b0, 64'h0123_4567_89AB_CDEF});
    @(negedge clk);
    chk("R10 new double", rd0_data, model(2'b10, 5'd12));
    chk("R10 new quad", rd1_data, model(2'b11, 5'd12));
  endtask

  task automatic t_dual();
    @(negedge clk);
    rd0_size = 2'b01; rd0_spec = 5'd5;
    rd1_size = 2'b11; rd1_spec = 5'd9;
    @(negedge clk);
    chk("R11 port0 single", rd0_data, model(2'b01, 5'd5));
    chk("R11 port1 upper quad", rd1_data, model(2'b11, 5'd9));
    rd0_size = 2'b11; rd0_spec = 5'd6;
    rd1_size = 2'b10; rd1_spec = 5'd14;
    @(negedge clk);
    chk("R11 port0 bad quad", {127'b0, rd0_bad}, {127'b0, 1'b1});
    chk("R11 port1 unaffected", rd1_data, model(2'b10, 5'd14));
    chk("R11 port1 flag clear", {127'b0, rd1_bad}, '0);
  endtask

  initial begin
    t_reset();
    t_singles();
    t_half();
    t_upper();
    t_quad();
    t_illegal();
    t_overlap();
    t_dual();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule